// File: doc/BRIEF.md
# Hybrid Register-Exchange Survivor Unit

This block is the survivor stage of a four-state, rate-1/2 Viterbi decoder. It takes one decision vector per accepted symbol, one decision bit per state, from the add-compare-select stage. It also keeps per-state survivor registers that hold the partially decoded bit string of each surviving path. A plain register exchange rewrites every survivor register on every symbol. This unit rewrites them only on every second accepted symbol. It then shifts in two bits at once, and those two bits are simply the label of the destination state. The register to copy from is the state's ancestor two symbols back. It is found by a two-step trace-back through the current decision vector and the one stored from the previous symbol.

The decoder drives `dec_valid` with each decision vector and raises `dec_last` with the final vector of a block. If the block has an odd length, the last symbol triggers a single-step update that appends one bit, so the output holds exactly one bit per symbol. When the final update is written, `done` pulses for one cycle and `surv0` (the state-0 survivor) holds the decoded block. That value stays frozen until `start` or reset. The encoder is assumed to end in state 0 (zero tail).

Top module: `hre_survivor_unit`

## Requirements
- R1: After reset, and in the cycle after `start` is sampled high, `surv0` is all zeros and `done` is 0.
- R2: Survivor registers change only on the 2nd, 4th, 6th, ... accepted symbol of a block and on a final odd symbol flagged by `dec_last`. Cycles with `dec_valid` low do not advance the count.
- R3: A paired update shifts the ancestor's register left by two and places the destination label in bits [1:0]. Bit 1 is the label's high bit (older input) and bit 0 is its low bit (newest input), so `surv0` always gains `00`.
- R4: A state is coded s = {older input, newest input}. The predecessor of s under decision d is {d, s[1]}, where d = `dec[s]`. A paired update applies this rule first with the current vector and then with the vector of the previous accepted symbol. Example: with `dec` = 4'hF on every symbol, `surv0` is 16'h000C after four symbols and 16'h003C after six.
- R5: For decisions along a noiseless path that ends in state 0, the final `surv0` equals the input sequence. The oldest bit sits at bit n-1 and the newest at bit 0, and the upper bits are zero.
- R6: When `dec_last` comes with an odd-numbered symbol, a single-step update copies the one-step predecessor shifted left by one and appends s[0]. Example: three symbols of `dec` = 4'hF give 16'h0004.
- R7: `done` is high for exactly one cycle, the cycle after the symbol with `dec_last` is accepted. `surv0` already holds the final value in that cycle.
- R8: Once `done` has fired, further `dec_valid` inputs, including ones with `dec_last`, are ignored. `surv0` is held and `done` stays low until `start` or reset.
- R9: `start` has priority over `dec_valid`. A symbol presented in the same cycle as `start` is discarded, and the next accepted symbol counts as the first of a new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears survivors and begins a new block |
| dec_valid | input | 1 | Decision vector valid this cycle |
| dec_last | input | 1 | Marks the final symbol of the block |
| dec | input | 4 | Decision bit per state, bit s for state s |
| surv0 | output | SURV_W | State-0 survivor register (decoded output) |
| done | output | 1 | One-cycle pulse when the final update is written |

## Verification
The assertions assume that `dec_last` is only meaningful while `dec_valid` is high. They also assume that a block is no longer than `SURV_W` symbols, so no decoded bit is shifted out of the top of a register. The bench respects both limits: every block is at most 16 symbols, and `dec_last` is raised only on a valid symbol. The stimulus puts the true decision bit on the true path's state and pseudo-random bits on the other states. This makes a correct trace-back the only way to recover the input sequence. Idle gaps are placed inside blocks to test that the pairing counts accepted symbols rather than clock cycles.

// File: rtl/hre_pkg.sv
// Package: shared types and trellis helpers for the hybrid survivor unit.
// Assumes a 4-state, rate-1/2 code; a state holds {older input, newest input}.
package hre_pkg;
    localparam int NUM_STATES = 4;
    localparam int STATE_BITS = 2;

    typedef logic [STATE_BITS-1:0] state_t;

    // One trace-back step: predecessor of s given its decision bit d.
    function automatic state_t prev_state(input state_t s, input logic d);
        return {d, s[1]};
    endfunction
endpackage

// File: rtl/hre_decision_buf.sv
// Module: holds the decision vector of the previous accepted symbol so the
// two-step trace-back can look one symbol further back than the live input.
// Assumes wr is only high for accepted symbols; clr empties the buffer.
module hre_decision_buf #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [NS-1:0] din,
    output logic [NS-1:0] dout
);
    logic [NS-1:0] held_q;

    // Capture each accepted vector; clear on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            held_q <= '0;
        end else if (wr) begin
            held_q <= din;
        end
    end

    assign dout = held_q;
endmodule

// File: rtl/hre_traceback.sv
// Module: combinational trace-back for every state. Gives the one-step
// ancestor (from the live vector) and the two-step ancestor (live vector,
// then previous vector). Flat outputs carry STATE_BITS per state.
module hre_traceback
    import hre_pkg::*;
#(
    parameter int NS = NUM_STATES
) (
    input  logic [NS-1:0]            cur_dec,
    input  logic [NS-1:0]            old_dec,
    output logic [NS*STATE_BITS-1:0] anc1,
    output logic [NS*STATE_BITS-1:0] anc2
);
    for (genvar g = 0; g < NS; g++) begin : g_state
        localparam state_t LBL = state_t'(g);
        state_t step1;
        state_t step2;

        // Walk back one symbol, then a second symbol through the older vector.
        always_comb begin
            step1 = prev_state(LBL, cur_dec[g]);
            step2 = prev_state(step1, old_dec[step1]);
        end

        assign anc1[g*STATE_BITS +: STATE_BITS] = step1;
        assign anc2[g*STATE_BITS +: STATE_BITS] = step2;
    end
endmodule

// File: rtl/hre_surv_bank.sv
// Module: the per-state survivor registers. A paired update copies the
// two-step ancestor and appends the state label; a single update copies the
// one-step ancestor and appends the label's low bit. Exposes state 0 only.
// Assumes upd2 and upd1 are never high together.
module hre_surv_bank
    import hre_pkg::*;
#(
    parameter int NS     = NUM_STATES,
    parameter int SURV_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     upd2,
    input  logic                     upd1,
    input  logic [NS*STATE_BITS-1:0] anc1,
    input  logic [NS*STATE_BITS-1:0] anc2,
    output logic [SURV_W-1:0]        s0_out
);
    logic [SURV_W-1:0] regs_q [NS];

    for (genvar g = 0; g < NS; g++) begin : g_reg
        localparam state_t LBL = state_t'(g);
        state_t            a1;
        state_t            a2;
        logic [SURV_W-1:0] nxt;

        assign a1 = anc1[g*STATE_BITS +: STATE_BITS];
        assign a2 = anc2[g*STATE_BITS +: STATE_BITS];

        // Choose the new contents from the selected ancestor plus label bits.
        always_comb begin
            nxt = regs_q[g];
            if (upd2) begin
                nxt = {regs_q[a2][SURV_W-STATE_BITS-1:0], LBL};
            end else if (upd1) begin
                nxt = {regs_q[a1][SURV_W-2:0], LBL[0]};
            end
        end

        // Write only on update cycles to keep toggling low.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                regs_q[g] <= '0;
            end else if (upd2 || upd1) begin
                regs_q[g] <= nxt;
            end
        end
    end

    assign s0_out = regs_q[0];
endmodule

// File: rtl/hre_survivor_unit.sv
// Module: top of the hybrid register-exchange survivor stage. Pairs accepted
// symbols, starts a two-step update on every second one, does a single-step
// update for an odd final symbol, then pulses done and freezes until start.
// Assumes block length <= SURV_W and that dec_last comes with dec_valid.
module hre_survivor_unit
    import hre_pkg::*;
#(
    parameter int SURV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  dec_valid,
    input  logic                  dec_last,
    input  logic [NUM_STATES-1:0] dec,
    output logic [SURV_W-1:0]     surv0,
    output logic                  done
);
    localparam int AW = NUM_STATES * STATE_BITS;

    logic                  odd_q;
    logic                  fin_q;
    logic                  done_q;
    logic                  accept;
    logic                  upd2;
    logic                  upd1;
    logic [NUM_STATES-1:0] old_dec;
    logic [AW-1:0]         anc1;
    logic [AW-1:0]         anc2;

    // Accept a symbol only while a block is open and no restart is pending.
    always_comb begin
        accept = dec_valid && !fin_q && !start;
        upd2   = accept && odd_q;
        upd1   = accept && !odd_q && dec_last;
    end

    // Track symbol parity, block completion and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            odd_q  <= 1'b0;
            fin_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept && dec_last;
            if (accept) begin
                odd_q <= dec_last ? 1'b0 : !odd_q;
                if (dec_last) begin
                    fin_q <= 1'b1;
                end
            end
        end
    end

    hre_decision_buf #(.NS(NUM_STATES)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .wr    (accept),
        .din   (dec),
        .dout  (old_dec)
    );

    hre_traceback #(.NS(NUM_STATES)) u_tb (
        .cur_dec (dec),
        .old_dec (old_dec),
        .anc1    (anc1),
        .anc2    (anc2)
    );

    hre_surv_bank #(.NS(NUM_STATES), .SURV_W(SURV_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .upd2   (upd2),
        .upd1   (upd1),
        .anc1   (anc1),
        .anc2   (anc2),
        .s0_out (surv0)
    );

    assign done = done_q;
endmodule

// File: rtl/hre_survivor_chk.sv
// Module: property checker bound to the survivor unit. Keeps its own view of
// symbol parity and block completion, derived from the ports only.
module hre_survivor_chk #(
    parameter int SURV_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              dec_valid,
    input logic              dec_last,
    input logic [SURV_W-1:0] surv0,
    input logic              done
);
    logic cpar;
    logic cfin;
    logic acc;

    assign acc = dec_valid && !cfin && !start;

    // Port-level model of pairing and of the finished state.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cpar <= 1'b0;
            cfin <= 1'b0;
        end else if (acc) begin
            cpar <= dec_last ? 1'b0 : !cpar;
            if (dec_last) begin
                cfin <= 1'b1;
            end
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (surv0 == '0 && !done)); // R1
    AST_ALTERNATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(acc && (cpar || dec_last))) |=> $stable(surv0)); // R2
    AST_LABEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cpar) |=> (surv0[1:0] == 2'b00)); // R3
    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && dec_last) |=> done); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_HOLD_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfin && !start) |=> ($stable(surv0) && !done)); // R8
endmodule

bind hre_survivor_unit hre_survivor_chk #(.SURV_W(SURV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dec_valid (dec_valid),
    .dec_last  (dec_last),
    .surv0     (surv0),
    .done      (done)
);

// File: tb/tb_hre_survivor_unit.sv
// Bench: scoreboard style. run_seq/drivers push expected survivor words;
// a negedge monitor pops one on each done pulse and compares.
module tb_hre_survivor_unit;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dec_valid = 1'b0;
    logic          dec_last = 1'b0;
    logic [3:0]    dec = '0;
    logic [SW-1:0] surv0;
    logic          done;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [15:0] lf = 16'hACE1;
    logic [SW-1:0] expq [$];
    logic done_prev = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    hre_survivor_unit #(.SURV_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dec_valid(dec_valid),
        .dec_last(dec_last), .dec(dec), .surv0(surv0), .done(done)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare on each done pulse; done must never last two cycles (R7).
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R8 unexpected done", {16'h0, surv0}, 32'h0);
            end else begin
                logic [SW-1:0] e;
                e = expq.pop_front();
                chk(surv0 == e, "R5 decoded word at done", {16'h0, surv0}, {16'h0, e});
            end
            chk(!done_prev, "R7 done one cycle", {31'h0, done_prev}, 32'h0);
        end
        done_prev = done;
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic sym(input logic [3:0] d, input logic lst);
        @(negedge clk);
        dec = d;
        dec_valid = 1'b1;
        dec_last = lst;
    endtask

    task automatic idle();
        @(negedge clk);
        dec_valid = 1'b0;
        dec_last = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        dec_valid = 1'b0;
        dec_last = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(surv0 == '0 && !done, "R1 start clears", {16'h0, surv0}, 32'h0);
    endtask

    function automatic logic bit_at(input logic [15:0] v, input int n, input int t);
        if (t < 0) return 1'b0;
        return v[n-1-t];
    endfunction

    // Drive a noiseless path (tail must end in state 0) with random off-path decisions.
    task automatic run_seq(input logic [15:0] v, input int n, input logic gap);
        logic [SW-1:0] msk;
        msk = (n >= SW) ? '1 : ((SW'(1) << n) - 1);
        expq.push_back(SW'(v) & msk);
        for (int t = 0; t < n; t++) begin
            logic [1:0] s;
            logic [3:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            s = {bit_at(v, n, t-1), bit_at(v, n, t)};
            d = lf[3:0];
            d[s] = bit_at(v, n, t-2);
            sym(d, t == n-1);
            if (gap && t == 2) idle();
        end
        idle();
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(surv0 == '0 && !done, "R1 reset state", {16'h0, surv0}, 32'h0);
        rst_n = 1'b1;

        // R4 / R2 / R3: all-ones decisions, checked mid-block.
        expq.push_back(16'h003C);
        sym(4'hF, 0); sym(4'hF, 0); sym(4'hF, 0); sym(4'hF, 0);
        idle();
        chk(surv0 == 16'h000C, "R4 trace after four symbols", {16'h0, surv0}, 32'h000C);
        chk(surv0[1:0] == 2'b00, "R3 label bits of state 0", {30'h0, surv0[1:0]}, 32'h0);
        sym(4'hF, 0);
        idle(); idle();
        chk(surv0 == 16'h000C, "R2 no write on odd symbol", {16'h0, surv0}, 32'h000C);
        sym(4'hF, 1);
        idle(); idle();
        chk(surv0 == 16'h003C, "R4 six symbols", {16'h0, surv0}, 32'h003C);

        // R8: symbols after done are ignored.
        sym(4'h5, 0); sym(4'hA, 1);
        idle(); idle();
        chk(surv0 == 16'h003C, "R8 held after done", {16'h0, surv0}, 32'h003C);

        // R6: odd length, single-step final update.
        do_start();
        expq.push_back(16'h0004);
        sym(4'hF, 0); sym(4'hF, 0); sym(4'hF, 1);
        idle(); idle();
        chk(surv0 == 16'h0004, "R6 odd final append", {16'h0, surv0}, 32'h0004);

        // R5: 12-bit sequence 110101011000, with a gap inside.
        do_start();
        run_seq(16'b0000110101011000, 12, 1'b1);

        // R6 / R5: 7-bit odd sequence.
        do_start();
        run_seq(16'b0000000001011100, 7, 1'b0);

        // R5: full-width 16-bit sequence.
        do_start();
        run_seq(16'b1011001110100100, 16, 1'b1);

        // R9: start with a simultaneous symbol discards that symbol.
        @(negedge clk);
        start = 1'b1; dec_valid = 1'b1; dec = 4'hF; dec_last = 1'b0;
        @(negedge clk);
        start = 1'b0; dec_valid = 1'b0;
        chk(surv0 == '0 && !done, "R9 start wins over symbol", {16'h0, surv0}, 32'h0);
        run_seq(16'b0000110101011000, 12, 1'b0);

        // R5: another odd block.
        do_start();
        run_seq(16'b0000000000011000, 5, 1'b1);

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R7 every block produced done", expq.size(), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule